// File: doc/BRIEF.md
# Interrupt Mask and Pending-Event Register Unit

This block collects the interrupt events of a serial port and decides which of them reach the processor. Each of thirteen source positions has a pending bit that latches a one-cycle event pulse, and a mask bit that decides whether that pending bit may raise the single interrupt line. Software never writes the mask directly. Writing ones to a set window turns mask bits on, and writing ones to a separate clear window turns them off. Bits written as zero keep their old value, so two agents can adjust different sources without a read-modify-write race.

Pending bits stay set until software writes a one to them. A live-level window shows the present state of the FIFO-related conditions (the receive trigger, receive empty, receive full, transmit empty and transmit full levels) whatever the mask holds. Software can therefore poll those conditions with their interrupts turned off. The event generators lie outside the block: they arrive as pulses on `evt_pulse` and as levels on `fifo_lvl`.

Register windows (3-bit word address): 0 mask-set, 1 mask-clear, 2 mask view, 3 pending (write 1 to clear), 4 live levels; every other address reads zero. Source bit positions, shared by every window: 0 receive trigger, 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full, 5 overrun, 6 framing error, 7 parity error, 8 receive timeout, 9 to 12 spare sources.

Top module: `intr_mask_unit`

## Requirements
- R1: A write to address 0 sets every mask bit whose data bit is 1, and leaves the mask bits whose data bit is 0 unchanged. The mask view (address 2) shows the new value in the cycle after the write.
- R2: A write to address 1 clears every mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R3: Reads of address 0 and of address 1 always return zero. Reads of any unmapped address (5 to 7) also return zero.
- R4: Only bits 12:0 are implemented. Bits 31:13 of every read are zero, and data bits 31:13 of a write have no effect.
- R5: An `evt_pulse` bit that is high at a clock edge sets the matching pending bit (address 3). The bit stays set after the pulse ends.
- R6: A write to address 3 clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 are not affected.
- R7: If an event pulse and a clearing write hit the same pending bit in the same cycle, the event wins and the bit stays set.
- R8: `irq` is a registered signal. It is high in the cycle after some bit is both pending and masked on, and low in the cycle after no such bit exists. A pending bit whose mask bit is 0 never raises `irq`.
- R9: Address 4 returns `fifo_lvl[4:0]` in bits 4:0 at the current level, whatever the mask and pending bits hold. Bits 12:5 of address 4 read zero.
- R10: Writes to addresses 2, 4 and 5 to 7 change no mask or pending bit.
- R11: Reset clears all mask bits, all pending bits and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_waddr | input | 3 | Word address of the write |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Word address of the read |
| reg_rdata | output | 32 | Read data for `reg_raddr`, combinational |
| evt_pulse | input | 13 | Event pulses, one bit per source |
| fifo_lvl | input | 5 | Live FIFO condition levels for sources 0 to 4 |
| irq | output | 1 | Interrupt request, registered |

## Verification
Two functions can act on the same pending bit in one cycle: an event pulse setting it and a software write clearing it. The bench drives the pulse and the write-1 to address 3 in the same cycle on bit 6. It then reads the pending window and expects bit 6 to stay set, while a second bit cleared in that same write must drop. A mask-set write that lands while a bit is already pending is also checked. `irq` must stay low in the first cycle after that write and go high in the cycle after that.

// File: rtl/intr_pkg.sv
package intr_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        WIN_MASK_SET = 3'd0,
        WIN_MASK_CLR = 3'd1,
        WIN_MASK_VIEW = 3'd2,
        WIN_PENDING  = 3'd3,
        WIN_LIVE     = 3'd4
    } win_e;

    // Source bit positions, shared by every window
    localparam int SRC_RX_TRIG  = 0;
    localparam int SRC_RX_EMPTY = 1;
    localparam int SRC_RX_FULL  = 2;
    localparam int SRC_TX_EMPTY = 3;
    localparam int SRC_TX_FULL  = 4;
    localparam int SRC_OVERRUN  = 5;
    localparam int SRC_FRAMING  = 6;
    localparam int SRC_PARITY   = 7;
    localparam int SRC_RX_TOUT  = 8;
endpackage

// File: rtl/intr_mask_reg.sv
module intr_mask_reg #(
    parameter int SRC_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_wr,
    input  logic             clr_wr,
    input  logic [SRC_W-1:0] wbits,
    output logic [SRC_W-1:0] mask_q
);
    logic [SRC_W-1:0] mask_d;

    always_comb begin
        mask_d = mask_q;
        if (set_wr) mask_d = mask_q | wbits;
        else if (clr_wr) mask_d = mask_q & ~wbits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    // R1: every bit written as 1 through the set window is on afterwards
    assert_mask_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((mask_q & $past(wbits)) == $past(wbits)));

    // R2: every bit written as 1 through the clear window is off afterwards
    assert_mask_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((mask_q & $past(wbits)) == '0));

    // R10: with no set or clear write the mask holds its value
    assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_wr && !clr_wr) |=> $stable(mask_q));
endmodule

// File: rtl/intr_pend_latch.sv
module intr_pend_latch #(
    parameter int SRC_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] evt,
    input  logic             clr_wr,
    input  logic [SRC_W-1:0] wbits,
    output logic [SRC_W-1:0] pend_q
);
    logic [SRC_W-1:0] clr_bits;
    logic [SRC_W-1:0] pend_d;

    assign clr_bits = clr_wr ? wbits : '0;

    // R7: the event term is ORed after the clear, so a colliding event wins
    always_comb pend_d = (pend_q & ~clr_bits) | evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // R5: every pulsed source is pending in the next cycle
    assert_evt_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((pend_q & $past(evt)) == $past(evt)));

    // R6: a pending bit only drops after a clearing write to the pending window
    assert_pend_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_q & ~pend_d)) |-> clr_wr);

    // R7: a bit pulsed during a clear still reads set afterwards
    assert_evt_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && |(evt & wbits)) |=> ((pend_q & $past(evt & wbits)) == $past(evt & wbits)));
endmodule

// File: rtl/intr_read_mux.sv
module intr_read_mux
    import intr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SRC_W  = 13,
    parameter int LIVE_W = 5
) (
    input  logic [ADDR_W-1:0] raddr,
    input  logic [SRC_W-1:0]  mask_q,
    input  logic [SRC_W-1:0]  pend_q,
    input  logic [LIVE_W-1:0] live,
    output logic [DATA_W-1:0] rdata
);
    logic [SRC_W-1:0] sel;
    logic [SRC_W-1:0] live_ext;

    assign live_ext = {{(SRC_W-LIVE_W){1'b0}}, live};

    always_comb begin
        unique case (raddr)
            WIN_MASK_VIEW: sel = mask_q;
            WIN_PENDING:   sel = pend_q;
            WIN_LIVE:      sel = live_ext;
            default:       sel = '0;   // set/clear windows and holes read zero (R3)
        endcase
    end

    assign rdata = {{(DATA_W-SRC_W){1'b0}}, sel};
endmodule

// File: rtl/intr_mask_unit.sv
module intr_mask_unit
    import intr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SRC_W  = 13,
    parameter int LIVE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_waddr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [SRC_W-1:0]  evt_pulse,
    input  logic [LIVE_W-1:0] fifo_lvl,
    output logic              irq
);
    logic [SRC_W-1:0] wbits;
    logic             set_wr, clr_wr, pend_wr;
    logic [SRC_W-1:0] mask_q, pend_q;
    logic             irq_d;

    // R4: write data above the implemented width is dropped here
    assign wbits   = reg_wdata[SRC_W-1:0];
    assign set_wr  = reg_wr && (reg_waddr == WIN_MASK_SET);
    assign clr_wr  = reg_wr && (reg_waddr == WIN_MASK_CLR);
    assign pend_wr = reg_wr && (reg_waddr == WIN_PENDING);

    intr_mask_reg #(.SRC_W(SRC_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .set_wr(set_wr), .clr_wr(clr_wr),
        .wbits(wbits), .mask_q(mask_q)
    );

    intr_pend_latch #(.SRC_W(SRC_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .evt(evt_pulse), .clr_wr(pend_wr),
        .wbits(wbits), .pend_q(pend_q)
    );

    intr_read_mux #(.DATA_W(DATA_W), .SRC_W(SRC_W), .LIVE_W(LIVE_W)) u_rd (
        .raddr(reg_raddr), .mask_q(mask_q), .pend_q(pend_q),
        .live(fifo_lvl), .rdata(reg_rdata)
    );

    assign irq_d = |(pend_q & mask_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= irq_d;
    end

    // R8: with the mask all zero, irq stays low in the next cycle
    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> !irq);

    // R8: irq follows a pending and masked-on bit one cycle later
    assert_irq_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_q & mask_q)) |=> irq);

    // R4: read data above the implemented width is zero
    always_comb begin
        if (rst_n) assert_rd_upper_R4: assert (reg_rdata[DATA_W-1:SRC_W] == '0);
    end
endmodule

// File: tb/intr_mask_unit_bench.sv
`timescale 1ns/1ps
module intr_mask_unit_bench;
    localparam int DW = 32;
    localparam int SW = 13;
    localparam int LW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_waddr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [2:0]    reg_raddr = '0;
    logic [DW-1:0] reg_rdata;
    logic [SW-1:0] evt_pulse = '0;
    logic [LW-1:0] fifo_lvl = '0;
    logic          irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    intr_mask_unit u_intr_mask_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .evt_pulse(evt_pulse), .fifo_lvl(fifo_lvl), .irq(irq)
    );

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
        reg_raddr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [SW-1:0] v);
        @(negedge clk);
        evt_pulse = v;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        rd(3'd2, d); chk("R11 mask after reset", d, 0);
        rd(3'd3, d); chk("R11 pending after reset", d, 0);
        chk("R11 irq after reset", irq, 0);
    endtask

    task automatic t_mask_set_clr();
        logic [DW-1:0] d;
        wr(3'd0, 32'h105);
        rd(3'd2, d); chk("R1 set 0x105", d, 32'h105);
        wr(3'd0, 32'h002);
        rd(3'd2, d); chk("R1 zero bits unchanged", d, 32'h107);
        wr(3'd1, 32'h004);
        rd(3'd2, d); chk("R2 clear bit 2", d, 32'h103);
        wr(3'd1, 32'h000);
        rd(3'd2, d); chk("R2 clear zero no effect", d, 32'h103);
        rd(3'd0, d); chk("R3 set window reads zero", d, 0);
        rd(3'd1, d); chk("R3 clear window reads zero", d, 0);
        rd(3'd6, d); chk("R3 hole reads zero", d, 0);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd2, d); chk("R4 upper bits dropped", d, 32'h1FFF);
        wr(3'd1, 32'hFFFF_E000);
        rd(3'd2, d); chk("R4 upper clear bits ignored", d, 32'h1FFF);
        wr(3'd1, 32'h1FFF);
        rd(3'd2, d); chk("R2 clear all", d, 0);
    endtask

    task automatic t_pending();
        logic [DW-1:0] d;
        pulse(13'h020);
        @(negedge clk);
        rd(3'd3, d); chk("R5 overrun latched", d, 32'h020);
        pulse(13'h180);
        rd(3'd3, d); chk("R5 parity and timeout latched", d, 32'h1A0);
        wr(3'd3, 32'h100);
        rd(3'd3, d); chk("R6 clear only bit 8", d, 32'h0A0);
        // R7 collision: pulse bit 6 while clearing bits 6 and 7
        @(negedge clk);
        evt_pulse = 13'h040; reg_wr = 1'b1; reg_waddr = 3'd3; reg_wdata = 32'h0C0;
        @(negedge clk);
        evt_pulse = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd(3'd3, d); chk("R7 event wins over clear", d, 32'h060);
        wr(3'd3, 32'h1FFF);
        rd(3'd3, d); chk("R6 clear all", d, 0);
    endtask

    task automatic t_irq();
        logic [DW-1:0] d;
        pulse(13'h008);
        @(negedge clk);
        chk("R8 unmasked pending gives no irq", irq, 0);
        wr(3'd0, 32'h008);
        chk("R8 irq not yet high one cycle after mask", irq, 0);
        @(negedge clk);
        chk("R8 irq high after mask", irq, 1);
        wr(3'd1, 32'h008);
        chk("R8 irq still high right after unmask", irq, 1);
        @(negedge clk);
        chk("R8 irq low after unmask", irq, 0);
        wr(3'd0, 32'h008);
        @(negedge clk);
        chk("R8 irq high again", irq, 1);
        wr(3'd3, 32'h008);
        @(negedge clk);
        chk("R8 irq low after pending clear", irq, 0);
        wr(3'd1, 32'h1FFF);
        rd(3'd3, d); chk("R8 pending empty", d, 0);
    endtask

    task automatic t_live();
        logic [DW-1:0] d;
        fifo_lvl = 5'b10110;
        rd(3'd4, d); chk("R9 live levels with mask zero", d, 32'h16);
        fifo_lvl = 5'b01001;
        rd(3'd4, d); chk("R9 live levels follow input", d, 32'h09);
        pulse(13'h1E0);
        rd(3'd4, d); chk("R9 error events absent from live", d, 32'h09);
        rd(3'd3, d); chk("R9 pending separate from live", d, 32'h1E0);
        fifo_lvl = '0;
        wr(3'd3, 32'h1FFF);
    endtask

    task automatic t_readonly();
        logic [DW-1:0] d;
        wr(3'd0, 32'h011);
        pulse(13'h002);
        wr(3'd2, 32'h1FFF);
        wr(3'd4, 32'h1FFF);
        wr(3'd5, 32'h1FFF);
        wr(3'd7, 32'h1FFF);
        rd(3'd2, d); chk("R10 mask unchanged by other windows", d, 32'h011);
        rd(3'd3, d); chk("R10 pending unchanged by other windows", d, 32'h002);
        // R11 reset mid-run
        wr(3'd0, 32'h002);
        @(negedge clk);
        chk("R11 irq high before reset", irq, 1);
        do_reset();
        rd(3'd2, d); chk("R11 mask cleared by reset", d, 0);
        rd(3'd3, d); chk("R11 pending cleared by reset", d, 0);
        chk("R11 irq cleared by reset", irq, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_set_clr();
        t_pending();
        t_irq();
        t_live();
        t_readonly();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule